// File: doc/BRIEF.md
# Slot-Wheel Bandwidth Arbiter with Round-Robin Reclaim

This block decides, on every clock cycle, which of N initiators may use a shared on-chip interconnect. Each decision has two stages. First, a wheel of time slots names the owner of the current slot. If that owner is requesting, the owner wins the cycle. If the owner is not requesting, or if the slot holds no reservation, the cycle is not wasted: it goes to the requesting initiators in round-robin order.

Software or a configuration agent fills the slot table through a one-word write port. Each table entry holds an initiator number and a valid flag. The number of slots an initiator holds sets its guaranteed share of the cycles. The wheel pointer moves forward one slot on every cycle and wraps at the table depth, whether or not anyone is requesting. The grant is registered and one-hot. The current slot index is visible at the block's edge.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: After reset, `grant` is all zero, `slot` is 0 and every slot table entry is invalid, so the first decisions are made by round robin starting at initiator 0.
- R2: `slot` increases by one on every rising clock edge out of reset and goes from DEPTH-1 back to 0. Requests have no effect on this movement.
- R3: When the entry at the current `slot` is valid and its initiator is requesting, that initiator is granted, whatever the round-robin pointer holds.
- R4: When the current entry is invalid, or its owner is not requesting, the grant goes to the first requesting initiator found by searching upward from the round-robin pointer, wrapping from N-1 to 0.
- R5: The round-robin pointer changes only on a round-robin grant, and it then becomes the granted index plus one, modulo N. Slot-owner grants and idle cycles leave the pointer unchanged.
- R6: `grant` has at most one bit set. Bit i means initiator i. `grant` is all zero exactly when no request was present at the deciding edge.
- R7: `grant` is registered. It reflects the `req` value and the `slot` value sampled at the preceding rising edge, and it holds steady between edges even if `req` changes.
- R8: A rising edge with `cfg_we` high stores `cfg_id` and `cfg_valid` into entry `cfg_addr`. The new entry takes part in decisions from the next edge on. Writing `cfg_valid`=0 removes the reservation.
- R9: With all initiators requesting throughout one full wheel revolution of DEPTH cycles, an initiator that holds k valid slots receives at least k grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request line per initiator |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_addr | input | $clog2(DEPTH) | Slot table entry to write |
| cfg_id | input | $clog2(N) | Initiator number stored in the entry |
| cfg_valid | input | 1 | Valid flag stored in the entry |
| grant | output | N | Registered one-hot grant |
| slot | output | $clog2(DEPTH) | Current wheel position |

## Verification
Each decision uses the `slot` value and the `req` value present before a rising edge. The matching grant appears one register later, just after that edge. The bench therefore drives `req` on the falling edge and records `slot` at that moment. It then checks `grant` and the incremented `slot` one time unit after the following rising edge. A table write is one cycle away from its first effect, so write cycles are kept separate from the cycles that check the new entry. To show that `grant` is held between edges, the bench also compares it against the previous result right after changing `req` in mid-cycle.

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter #(
  parameter int N     = 4,
  parameter int DEPTH = 16,
  localparam int IDW  = (N > 1) ? $clog2(N) : 1,
  localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_addr,
  input  logic [IDW-1:0] cfg_id,
  input  logic           cfg_valid,
  output logic [N-1:0]   grant,
  output logic [SW-1:0]  slot
);

  logic [IDW-1:0] tbl_id [DEPTH];
  logic           tbl_v  [DEPTH];
  logic [IDW-1:0] rr_ptr;

  logic [IDW-1:0] owner;
  logic           own_hit;
  logic           rr_hit;
  logic [IDW-1:0] rr_idx;
  logic [N-1:0]   nxt_grant;

  function automatic logic [IDW:0] rr_pick(input logic [N-1:0] r, input logic [IDW-1:0] p);
    logic [IDW:0] res;
    res = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (r[(int'(p) + k) % N]) res = {1'b1, IDW'((int'(p) + k) % N)};
    end
    return res;
  endfunction

  assign owner   = tbl_id[slot];
  assign own_hit = tbl_v[slot] && (int'(owner) < N) && req[owner];
  assign {rr_hit, rr_idx} = rr_pick(req, rr_ptr);

  always_comb begin
    nxt_grant = '0;
    if (own_hit)     nxt_grant[owner]  = 1'b1;
    else if (rr_hit) nxt_grant[rr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      grant  <= '0;
      rr_ptr <= '0;
    end else begin
      slot  <= (slot == SW'(DEPTH - 1)) ? '0 : slot + 1'b1;
      grant <= nxt_grant;
      if (!own_hit && rr_hit)
        rr_ptr <= (int'(rr_idx) == N - 1) ? '0 : rr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl_v[i]  <= 1'b0;
        tbl_id[i] <= '0;
      end
    end else if (cfg_we) begin
      tbl_v[cfg_addr]  <= cfg_valid;
      tbl_id[cfg_addr] <= cfg_id;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant == '0)); // R6
  AST_BUSY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> (grant != '0)); // R6
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant & ~$past(req)) == '0)); // R4
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot == (($past(slot) == SW'(DEPTH - 1)) ? '0 : $past(slot) + 1'b1))); // R2
  AST_OWNER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    own_hit |=> grant[$past(owner)]); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (own_hit || req == '0) |=> $stable(rr_ptr)); // R5

endmodule

// File: tb/sim_tdma_rr_arbiter.sv
`timescale 1ns/1ps
module sim_tdma_rr_arbiter;
  localparam int N = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [1:0] cfg_id = '0;
  logic cfg_valid = 1'b0;
  logic [N-1:0] grant;
  logic [3:0] slot;

  int errors = 0;
  int checks = 0;
  int m_id [DEPTH];
  bit m_v [DEPTH];
  int m_rr = 0;
  logic [N-1:0] last_exp = '0;
  int cnt [N];

  always #2.5 clk = ~clk;

  tdma_rr_arbiter #(.N(N), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_id(cfg_id), .cfg_valid(cfg_valid), .grant(grant), .slot(slot));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int id, bit v);
    @(negedge clk);
    req = '0; cfg_we = 1'b1; cfg_addr = 4'(a); cfg_id = 2'(id); cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_id[a] = id; m_v[a] = v;
    last_exp = '0;
  endtask

  task automatic step(logic [N-1:0] r, string tag);
    int s;
    logic [N-1:0] e;
    @(negedge clk);
    req = r;
    #0.5;
    chk("R7 grant held between edges", int'(grant), int'(last_exp));
    s = int'(slot);
    e = '0;
    if (m_v[s] && r[m_id[s]]) e[m_id[s]] = 1'b1;
    else begin
      for (int k = 0; k < N; k++) begin
        if (e == '0 && r[(m_rr + k) % N]) begin
          e[(m_rr + k) % N] = 1'b1;
          m_rr = ((m_rr + k) % N + 1) % N;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(tag, int'(grant), int'(e));
    chk("R2 slot step", int'(slot), (s + 1) % DEPTH);
    for (int i = 0; i < N; i++) if (grant[i]) cnt[i]++;
    last_exp = e;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset grant", int'(grant), 0);
    chk("R1 reset slot", int'(slot), 0);
    @(negedge clk); rst_n = 1'b1;
    step(4'b1111, "R1 invalid table, rr from 0");
  endtask

  task automatic t_wrap;
    for (int c = 0; c < 20; c++) step(4'b0000, "R6 no request no grant");
  endtask

  task automatic t_rr;
    step(4'b1111, "R4 rr all");
    step(4'b1111, "R4 rr all");
    step(4'b1111, "R4 rr all wrap");
    step(4'b1111, "R4 rr all wrap");
    step(4'b1010, "R4 rr sparse");
    step(4'b1010, "R4 rr sparse");
    step(4'b0001, "R5 rr single");
    step(4'b0110, "R5 rr after single");
  endtask

  task automatic t_tdma;
    for (int a = 0; a < DEPTH; a++) wr(a, 3, 1'b1);
    for (int c = 0; c < 4; c++) step(4'b1111, "R3 owner wins");
    step(4'b0111, "R4 owner idle reclaim");
    step(4'b1001, "R3 owner wins over rr");
    step(4'b0011, "R5 rr pointer held by owner grants");
  endtask

  task automatic t_clear;
    for (int a = 0; a < DEPTH; a++) wr(a, 0, 1'b0);
    for (int c = 0; c < 4; c++) step(4'b1100, "R8 cleared entries use rr");
  endtask

  task automatic t_share;
    for (int a = 0; a < DEPTH; a++) begin
      if (a < 8)       wr(a, 0, 1'b1);
      else if (a < 12) wr(a, 1, 1'b1);
      else if (a < 14) wr(a, 2, 1'b1);
      else             wr(a, 0, 1'b0);
    end
    for (int i = 0; i < N; i++) cnt[i] = 0;
    for (int c = 0; c < DEPTH; c++) step(4'b1111, "R9 share cycle");
    chk("R9 share 0 at least 8", int'(cnt[0] >= 8), 1);
    chk("R9 share 1 at least 4", int'(cnt[1] >= 4), 1);
    chk("R9 share 2 at least 2", int'(cnt[2] >= 2), 1);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin m_id[a] = 0; m_v[a] = 1'b0; end
    for (int i = 0; i < N; i++) cnt[i] = 0;
    t_reset;
    t_wrap;
    t_rr;
    t_tdma;
    t_clear;
    t_share;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule